// File: doc/BRIEF.md
# Five-Operand Column-Counter Adder

This block adds five unsigned operands of a parameterised width `W` and returns the sum reduced modulo 2^W. It is purely combinational: operands go in, and the wrapped sum appears on the output in the same cycle. No clock or reset is involved.

The reduction does not chain three carry-save stages. Each bit column instead feeds one compressor that counts the ones among its five inputs. The count comes out as three bits with weights 1, 2 and 4. Across all columns these bits form three vectors. The weight-2 vector is shifted left by one place and the weight-4 vector by two places, and the three vectors are then added together. The parameter `USE_CSA` picks how that final addition is built:

- `USE_CSA = 1` uses one 3:2 carry-save row followed by a W-bit ripple carry-propagate adder.
- `USE_CSA = 0` uses two W-bit ripple carry-propagate adders in series.

The block has no internal states or transitions, so nothing is sequenced. Every path is a fixed layer of logic: counters, then the optional carry-save row, then carry propagation.

Top module: `pc5_adder`

## Requirements
- R1: Each column compressor outputs the number of ones among its five equal-weight input bits, encoded as a weight-1 bit, a weight-2 bit and a weight-4 bit.
- R2: A column whose five inputs are all 1 yields weight-4 bit = 1, weight-2 bit = 0 and weight-1 bit = 1. With every operand all ones, `sum_y` therefore equals 2^W − 5 (251 for W = 8).
- R3: `sum_y` equals (opnd_a + opnd_b + opnd_c + opnd_d + opnd_e) mod 2^W for any operand values.
- R4: Any part of the sum at or above bit position W is discarded. For example, five operands of 0x80 give 0x80 for W = 8.
- R5: With every operand zero, `sum_y` is zero.
- R6: Both settings of `USE_CSA` produce an identical `sum_y` for identical operands.
- R7: The result does not depend on which operand port carries which value. Permuting the five operands leaves `sum_y` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | W | first operand |
| opnd_b | input | W | second operand |
| opnd_c | input | W | third operand |
| opnd_d | input | W | fourth operand |
| opnd_e | input | W | fifth operand |
| sum_y | output | W | sum of the five operands modulo 2^W |

## Verification
The bench drives a single one through every bit of every operand. A compressor that wired its weights to the wrong positions would produce a wrong power of two there. It also drives all ones, where each column counts five. That input catches any counter that mis-encodes 5 or drops the weight-4 bit.

Operands of 0x80 produce carries that leave the word entirely. A design that saturated instead of wrapping, or that let the top carry fold back into the result, would fail that case.

Random and permuted operand sets are applied to both build variants at once. A shift that is off by one place, or a carry-save carry that is not shifted, shows up as a mismatch between the two variants or against the reference sum.

// File: rtl/pc5_pkg.sv
package pc5_pkg;
    // Number of operands reduced per column.
    localparam int unsigned NUM_OPND = 5;
    // Width of one column count (counts 0..5 need 3 bits).
    localparam int unsigned CNT_W    = 3;
endpackage

// File: rtl/pc5_counter.sv
module pc5_counter
    import pc5_pkg::*;
(
    input  logic [NUM_OPND-1:0] bits_in,
    output logic                cnt_s0,
    output logic                cnt_s1,
    output logic                cnt_s2
);
    logic fa0_sum, fa0_cry;
    logic fa1_cry;

    // First full adder: three inputs become a partial sum and a carry.
    always_comb begin
        fa0_sum = bits_in[0] ^ bits_in[1] ^ bits_in[2];
        fa0_cry = (bits_in[0] & bits_in[1]) | (bits_in[0] & bits_in[2]) |
                  (bits_in[1] & bits_in[2]);
    end

    // Second full adder: folds in the remaining two bits.
    always_comb begin
        cnt_s0  = fa0_sum ^ bits_in[3] ^ bits_in[4];
        fa1_cry = (fa0_sum & bits_in[3]) | (fa0_sum & bits_in[4]) |
                  (bits_in[3] & bits_in[4]);
    end

    // Half adder on the two weight-2 carries.
    always_comb begin
        cnt_s1 = fa0_cry ^ fa1_cry;
        cnt_s2 = fa0_cry & fa1_cry;
    end

    // The encoded count must match the population count of the column.
    always_comb begin
        p_count_match_r1: assert ({cnt_s2, cnt_s1, cnt_s0} ==
                                  CNT_W'($countones(bits_in)))
            else $error("column count differs from popcount");
        // An all-ones column must be encoded as 5 (101).
        p_full_column_r2: assert (!(&bits_in) ||
                                  (cnt_s2 && !cnt_s1 && cnt_s0))
            else $error("full column not encoded as five");
    end
endmodule

// File: rtl/pc5_csa.sv
module pc5_csa #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] sav_sum,
    output logic [W-1:0] sav_cry_sh   // carries already moved up one place
);
    assign sav_sum       = in_x ^ in_y ^ in_z;
    assign sav_cry_sh[0] = 1'b0;

    // Only the carries that stay inside the word are formed.
    genvar gi;
    generate
        for (gi = 0; gi < W - 1; gi++) begin : g_maj
            assign sav_cry_sh[gi+1] = (in_x[gi] & in_y[gi]) |
                                      (in_x[gi] & in_z[gi]) |
                                      (in_y[gi] & in_z[gi]);
        end
    endgenerate

    // Carry-save invariant: the two outputs keep the three-input sum.
    always_comb begin
        p_csa_keeps_sum_r3: assert (W'(sav_sum + sav_cry_sh) ==
                                    W'(in_x + in_y + in_z))
            else $error("carry-save row lost value");
    end
endmodule

// File: rtl/pc5_cpa.sv
module pc5_cpa #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] add_a,
    input  logic [W-1:0] add_b,
    output logic [W-1:0] add_sum
);
    // Ripple chain; the carry out of the top bit is never formed.
    logic [W-1:0] rip;

    assign rip[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            assign add_sum[gi] = add_a[gi] ^ add_b[gi] ^ rip[gi];
            if (gi < W - 1) begin : g_cry
                assign rip[gi+1] = (add_a[gi] & add_b[gi]) |
                                   (rip[gi] & (add_a[gi] ^ add_b[gi]));
            end
        end
    endgenerate
endmodule

// File: rtl/pc5_adder.sv
module pc5_adder
    import pc5_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter bit          USE_CSA = 1'b1
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic [W-1:0] opnd_c,
    input  logic [W-1:0] opnd_d,
    input  logic [W-1:0] opnd_e,
    output logic [W-1:0] sum_y
);
    localparam int unsigned WIDE = W + CNT_W - 1;

    // Per-column count bits, grouped by weight.
    logic [W-1:0] ones_v, twos_v, fours_v;
    // The three vectors aligned to their weights inside the word.
    logic [W-1:0] vec0, vec1, vec2;

    genvar gc;
    generate
        for (gc = 0; gc < W; gc++) begin : g_col
            pc5_counter u_cnt (
                .bits_in ({opnd_e[gc], opnd_d[gc], opnd_c[gc],
                           opnd_b[gc], opnd_a[gc]}),
                .cnt_s0  (ones_v[gc]),
                .cnt_s1  (twos_v[gc]),
                .cnt_s2  (fours_v[gc])
            );
        end
    endgenerate

    assign vec0 = ones_v;
    assign vec1 = {twos_v[W-2:0], 1'b0};
    assign vec2 = {fours_v[W-3:0], 2'b00};

    generate
        if (USE_CSA) begin : g_csa_path
            logic [W-1:0] row_sum, row_cry;
            pc5_csa #(.W(W)) u_csa (
                .in_x      (vec0),
                .in_y      (vec1),
                .in_z      (vec2),
                .sav_sum   (row_sum),
                .sav_cry_sh(row_cry)
            );
            pc5_cpa #(.W(W)) u_cpa (
                .add_a  (row_sum),
                .add_b  (row_cry),
                .add_sum(sum_y)
            );
        end else begin : g_two_cpa
            logic [W-1:0] part;
            pc5_cpa #(.W(W)) u_cpa0 (
                .add_a  (vec0),
                .add_b  (vec1),
                .add_sum(part)
            );
            pc5_cpa #(.W(W)) u_cpa1 (
                .add_a  (part),
                .add_b  (vec2),
                .add_sum(sum_y)
            );
        end
    endgenerate

    // The result is the full-width recombination, truncated to W bits.
    always_comb begin
        p_recombine_r3: assert (sum_y == W'({{(CNT_W-1){1'b0}}, ones_v} +
                                            {1'b0, twos_v, 1'b0} +
                                            {fours_v, 2'b00}))
            else $error("recombined counts disagree with output");
        // The output must match the operand sum with upper bits dropped.
        p_no_overflow_r4: assert (sum_y == W'(WIDE'(opnd_a) + WIDE'(opnd_b) +
                                              WIDE'(opnd_c) + WIDE'(opnd_d) +
                                              WIDE'(opnd_e)))
            else $error("output is not the wrapped operand sum");
    end

    initial begin
        p_width_ok: assert (W >= 3) else $error("W must be at least 3");
    end
endmodule

// File: tb/pc5_adder_bench.sv
`timescale 1ns/1ps
module pc5_adder_bench;
    localparam int unsigned W = 8;
    localparam logic [31:0] MASK = (32'd1 << W) - 32'd1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [W-1:0] a, b, c, d, e;
    logic [W-1:0] y_csa, y_cpa;
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    pc5_adder #(.W(W), .USE_CSA(1'b1)) u_pc5_adder (
        .opnd_a(a), .opnd_b(b), .opnd_c(c), .opnd_d(d), .opnd_e(e),
        .sum_y(y_csa));

    pc5_adder #(.W(W), .USE_CSA(1'b0)) u_pc5_adder_cpa (
        .opnd_a(a), .opnd_b(b), .opnd_c(c), .opnd_d(d), .opnd_e(e),
        .sum_y(y_cpa));

    function automatic logic [W-1:0] ref_sum(input logic [W-1:0] p, q, r, s, t);
        logic [31:0] acc;
        acc = 32'(p) + 32'(q) + 32'(r) + 32'(s) + 32'(t);
        return W'(acc & MASK);
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp_v);
        n_cmp++;
        if (y_csa !== exp_v) begin
            n_bad++;
            $display("FAIL %s csa variant: got %0d expected %0d", req, y_csa, exp_v);
        end
        n_cmp++;
        if (y_cpa !== exp_v) begin
            n_bad++;
            $display("FAIL %s two-adder variant: got %0d expected %0d", req, y_cpa, exp_v);
        end
    endtask

    // Apply operands on a falling edge, sample before the next rising edge.
    task automatic apply(input logic [W-1:0] p, q, r, s, t);
        @(negedge clk);
        a = p; b = q; c = r; d = s; e = t;
        #2;
    endtask

    task automatic t_zero();          // R5
        apply('0, '0, '0, '0, '0);
        check("R5", '0);
    endtask

    task automatic t_all_ones();      // R2: each column counts five
        apply('1, '1, '1, '1, '1);
        check("R2", W'((32'd1 << W) - 32'd5));
    endtask

    task automatic t_wrap();          // R4: carries above W-1 dropped
        apply(8'h80, 8'h80, 8'h80, 8'h80, 8'h80);
        check("R4", 8'h80);
        apply(8'hFF, 8'h01, 8'h00, 8'h00, 8'h00);
        check("R4", 8'h00);
        apply(8'hC0, 8'hC0, 8'hC0, 8'h40, 8'h40);
        check("R4", ref_sum(8'hC0, 8'hC0, 8'hC0, 8'h40, 8'h40));
    endtask

    task automatic t_walk();          // R1: single one in each column, each operand
        for (int op = 0; op < 5; op++) begin
            for (int bt = 0; bt < W; bt++) begin
                logic [W-1:0] v [5];
                for (int k = 0; k < 5; k++) v[k] = '0;
                v[op] = W'(1) << bt;
                apply(v[0], v[1], v[2], v[3], v[4]);
                check("R1", W'(1) << bt);
            end
        end
        // Column counts 2, 3, 4 in bit 0 and bit 3.
        apply(8'h09, 8'h09, 8'h00, 8'h00, 8'h00); check("R1", 8'h12);
        apply(8'h09, 8'h09, 8'h09, 8'h00, 8'h00); check("R1", 8'h1B);
        apply(8'h09, 8'h09, 8'h09, 8'h09, 8'h00); check("R1", 8'h24);
    endtask

    task automatic t_random(input int n);   // R3 and R6
        for (int i = 0; i < n; i++) begin
            logic [W-1:0] p, q, r, s, t;
            p = W'($urandom); q = W'($urandom); r = W'($urandom);
            s = W'($urandom); t = W'($urandom);
            apply(p, q, r, s, t);
            check("R3", ref_sum(p, q, r, s, t));
            n_cmp++;
            if (y_csa !== y_cpa) begin
                n_bad++;
                $display("FAIL R6: got %0d expected %0d", y_cpa, y_csa);
            end
        end
    endtask

    task automatic t_permute();       // R7
        logic [W-1:0] base;
        apply(8'h13, 8'hA7, 8'h5C, 8'hEE, 8'h01);
        base = ref_sum(8'h13, 8'hA7, 8'h5C, 8'hEE, 8'h01);
        check("R7", base);
        apply(8'h01, 8'hEE, 8'h13, 8'h5C, 8'hA7);
        check("R7", base);
        apply(8'h5C, 8'h01, 8'hA7, 8'h13, 8'hEE);
        check("R7", base);
    endtask

    initial begin
        a = '0; b = '0; c = '0; d = '0; e = '0;
        repeat (2) @(negedge clk);
        check("R5", '0);   // idle state with zero operands
        t_zero();
        t_all_ones();
        t_wrap();
        t_walk();
        t_permute();
        t_random(500);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule